// File: doc/BRIEF.md
# Branch Resolve and Predict Unit

This unit sits beside the decode and execute stages of a pipeline whose instructions are 32 bits wide and always sit on 4-byte boundaries. For each control-flow instruction, it does two things:

- It forms a static guess of the next fetch address.
- It resolves the real outcome from the test operand or the jump base register.

It then reports whether the guess was wrong. Forward conditional branches are guessed not taken. Backward ones are guessed taken. A small return-address stack, driven by call and return marks on each instruction, supplies the guess for computed returns.

All results come out of one register stage. A strobed instruction presented at a rising clock edge shows its results on the outputs from that edge until the next one. The return stack is updated on the same edge. Unconditional branches and computed jumps also produce link write data, which is the updated PC. A write to register index 31 is dropped.

Top module: `branch_resolve_unit`

## Requirements
- R1: The branch target is the updated PC plus the 21-bit displacement, sign-extended and shifted left by two. A taken conditional branch resolves to this target, and so does an unconditional branch. A not-taken conditional branch resolves to the updated PC.
- R2: For integer tests, `cond_sel` selects the test as follows:
  - 0: operand equal to zero.
  - 1: operand not zero.
  - 2: less than zero.
  - 3: less than or equal to zero.
  - 4: greater than zero.
  - 5: greater than or equal to zero.
  - 6: bit 0 clear (even).
  - 7: bit 0 set (odd).
- R3: When `fp_test` is 1, the sign is bit 63 and the value counts as zero when bits 62:0 are all zero, so negative zero is zero. Selectors 0 to 5 keep their meaning. Selectors 6 and 7 are never taken.
- R4: A conditional branch is predicted taken exactly when displacement bit 20 is 1. The predicted next address is the branch target when predicted taken, otherwise the updated PC.
- R5: `br_kind` encodes 00 as conditional, 01 as unconditional, and 1x as a computed jump. Unconditional branches and jumps are always taken. A jump resolves to `jump_base` with bits 1:0 cleared.
- R6: A jump marked return (`flow_mark` 10) while the stack holds entries is predicted to the stack top. Any other jump is predicted to the updated PC with bits 15:2 replaced by `tgt_hint`. Unconditional branches are predicted to the branch target.
- R7: For unconditional branches and jumps, `link_we` is 1 and `link_data` is the updated PC, unless `link_idx` is 31. When there is no write, `link_we` is 0 and `link_data` is 0.
- R8: The return stack behaves as follows:
  - It holds 4 entries.
  - A call mark (`flow_mark` 01) pushes the updated PC.
  - A return mark pops one entry.
  - A push onto a full stack discards the oldest entry.
  - A pop of an empty stack has no effect.
- R9: `mispredict` is 1 when the predicted taken flag differs from the resolved one, or when the predicted next address differs from the resolved next address.
- R10: Outputs are registered, with one cycle from strobe to result. While `out_valid` is 0, the signals `taken`, `mispredict` and `link_we` are 0. Reset clears all outputs and empties the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| upd_pc | input | 64 | Updated PC (address after the branch) |
| disp | input | 21 | Signed instruction displacement |
| cond_sel | input | 3 | Test selector |
| fp_test | input | 1 | Operand is floating point |
| test_val | input | 64 | Test operand |
| br_kind | input | 2 | Branch kind |
| jump_base | input | 64 | Jump base register value |
| tgt_hint | input | 14 | Low target bits guess for jumps |
| flow_mark | input | 2 | 01 call, 10 return, other none |
| link_idx | input | 5 | Link register index |
| out_valid | output | 1 | Result strobe |
| pred_next | output | 64 | Predicted next fetch address |
| res_next | output | 64 | Resolved next fetch address |
| taken | output | 1 | Resolved taken flag |
| mispredict | output | 1 | Prediction was wrong |
| link_we | output | 1 | Link register write enable |
| link_data | output | 64 | Link register write data |

## Verification
The hardest situations to reach are a full return stack losing its oldest entry, and a return arriving once the stack has drained. Random call and return marks seldom produce five calls in a row followed by five returns. A directed sequence therefore does exactly that. The fifth return must fall back to the hint guess, and the earlier pops must return addresses in reverse push order with the first push gone. Random stimulus, weighted toward zero, one, minus one and negative zero operands, covers the test decoding and both displacement signs.

// File: rtl/brp_pkg.sv
package brp_pkg;
    localparam logic [1:0] KIND_COND   = 2'b00;
    localparam logic [1:0] KIND_UNCOND = 2'b01;
    localparam logic [1:0] MARK_CALL   = 2'b01;
    localparam logic [1:0] MARK_RET    = 2'b10;

    typedef enum logic [2:0] {
        TST_EQ   = 3'd0,
        TST_NE   = 3'd1,
        TST_LT   = 3'd2,
        TST_LE   = 3'd3,
        TST_GT   = 3'd4,
        TST_GE   = 3'd5,
        TST_EVEN = 3'd6,
        TST_ODD  = 3'd7
    } test_e;
endpackage

// File: rtl/brp_cond_eval.sv
module brp_cond_eval #(
    parameter int DW = 64
) (
    input  logic [2:0]    sel,
    input  logic          fp_mode,
    input  logic [DW-1:0] val,
    output logic          hit
);
    import brp_pkg::*;

    logic is_zero;
    logic is_neg;

    always_comb begin
        if (fp_mode) begin
            is_zero = (val[DW-2:0] == '0);
        end else begin
            is_zero = (val == '0);
        end
        is_neg = val[DW-1] && !is_zero;
        case (test_e'(sel))
            TST_EQ:   hit = is_zero;
            TST_NE:   hit = !is_zero;
            TST_LT:   hit = is_neg;
            TST_LE:   hit = is_neg || is_zero;
            TST_GT:   hit = !is_neg && !is_zero;
            TST_GE:   hit = !is_neg;
            TST_EVEN: hit = !fp_mode && !val[0];
            default:  hit = !fp_mode && val[0];
        endcase
    end
endmodule

// File: rtl/brp_target_gen.sv
module brp_target_gen #(
    parameter int AW     = 64,
    parameter int DISP_W = 21,
    parameter int HINT_W = 14
) (
    input  logic [AW-1:0]     pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [AW-1:0]     jbase,
    input  logic [HINT_W-1:0] hint,
    output logic [AW-1:0]     br_tgt,
    output logic [AW-1:0]     jmp_tgt,
    output logic [AW-1:0]     hint_tgt
);
    localparam int EXT_W = AW - DISP_W - 2;

    logic [AW-1:0] offset;

    always_comb begin
        offset   = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
        br_tgt   = pc + offset;
        jmp_tgt  = {jbase[AW-1:2], 2'b00};
        hint_tgt = {pc[AW-1:HINT_W+2], hint, 2'b00};
    end
endmodule

// File: rtl/brp_ret_stack.sv
module brp_ret_stack #(
    parameter int AW    = 64,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top,
    output logic          nonempty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] ent;
        logic [CW-1:0]            cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (push && !pop) begin
            stk_d.ent[0] = push_val;
            for (int i = 1; i < DEPTH; i++) begin
                stk_d.ent[i] = stk_q.ent[i-1];
            end
            if (stk_q.cnt != FULL) begin
                stk_d.cnt = stk_q.cnt + 1'b1;
            end
        end else if (pop && !push && stk_q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                stk_d.ent[i] = stk_q.ent[i+1];
            end
            stk_d.ent[DEPTH-1] = '0;
            stk_d.cnt = stk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign top      = stk_q.ent[0];
    assign nonempty = (stk_q.cnt != '0);

    // R8: depth is never exceeded
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.cnt <= FULL);
    // R8: a lone push leaves its value on top
    a_r8_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (top == $past(push_val) && nonempty));
    // R8: popping an empty stack leaves it empty
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !nonempty) |=> !nonempty);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit #(
    parameter int AW        = 64,
    parameter int DW        = 64,
    parameter int DISP_W    = 21,
    parameter int HINT_W    = 14,
    parameter int RAS_DEPTH = 4,
    parameter int RIDX_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [AW-1:0]     upd_pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [2:0]        cond_sel,
    input  logic              fp_test,
    input  logic [DW-1:0]     test_val,
    input  logic [1:0]        br_kind,
    input  logic [AW-1:0]     jump_base,
    input  logic [HINT_W-1:0] tgt_hint,
    input  logic [1:0]        flow_mark,
    input  logic [RIDX_W-1:0] link_idx,
    output logic              out_valid,
    output logic [AW-1:0]     pred_next,
    output logic [AW-1:0]     res_next,
    output logic              taken,
    output logic              mispredict,
    output logic              link_we,
    output logic [AW-1:0]     link_data
);
    import brp_pkg::*;

    localparam logic [RIDX_W-1:0] ZERO_REG = '1;

    typedef struct packed {
        logic          valid;
        logic          taken;
        logic          mispredict;
        logic          link_we;
        logic [AW-1:0] pred_next;
        logic [AW-1:0] res_next;
        logic [AW-1:0] link_data;
    } out_t;

    out_t out_d, out_q;

    logic          cond_hit;
    logic [AW-1:0] br_tgt, jmp_tgt, hint_tgt;
    logic [AW-1:0] ras_top;
    logic          ras_nonempty;
    logic          do_push, do_pop;
    logic          pred_taken;

    brp_cond_eval #(.DW(DW)) u_cond (
        .sel     (cond_sel),
        .fp_mode (fp_test),
        .val     (test_val),
        .hit     (cond_hit)
    );

    brp_target_gen #(.AW(AW), .DISP_W(DISP_W), .HINT_W(HINT_W)) u_tgt (
        .pc       (upd_pc),
        .disp     (disp),
        .jbase    (jump_base),
        .hint     (tgt_hint),
        .br_tgt   (br_tgt),
        .jmp_tgt  (jmp_tgt),
        .hint_tgt (hint_tgt)
    );

    assign do_push = in_valid && (flow_mark == MARK_CALL);
    assign do_pop  = in_valid && (flow_mark == MARK_RET);

    brp_ret_stack #(.AW(AW), .DEPTH(RAS_DEPTH)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .push_val (upd_pc),
        .top      (ras_top),
        .nonempty (ras_nonempty)
    );

    always_comb begin
        out_d = '0;
        pred_taken = 1'b0;
        if (in_valid) begin
            out_d.valid = 1'b1;
            if (br_kind == KIND_COND) begin
                pred_taken      = disp[DISP_W-1];
                out_d.pred_next = pred_taken ? br_tgt : upd_pc;
                out_d.taken     = cond_hit;
                out_d.res_next  = cond_hit ? br_tgt : upd_pc;
            end else if (br_kind == KIND_UNCOND) begin
                pred_taken      = 1'b1;
                out_d.pred_next = br_tgt;
                out_d.taken     = 1'b1;
                out_d.res_next  = br_tgt;
            end else begin
                pred_taken      = 1'b1;
                out_d.pred_next = (flow_mark == MARK_RET && ras_nonempty) ? ras_top : hint_tgt;
                out_d.taken     = 1'b1;
                out_d.res_next  = jmp_tgt;
            end
            out_d.mispredict = (pred_taken != out_d.taken) ||
                               (out_d.pred_next != out_d.res_next);
            if (br_kind != KIND_COND && link_idx != ZERO_REG) begin
                out_d.link_we   = 1'b1;
                out_d.link_data = upd_pc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid  = out_q.valid;
    assign pred_next  = out_q.pred_next;
    assign res_next   = out_q.res_next;
    assign taken      = out_q.taken;
    assign mispredict = out_q.mispredict;
    assign link_we    = out_q.link_we;
    assign link_data  = out_q.link_data;

    // R10: idle cycles raise no flags
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!taken && !mispredict && !link_we));
    // R5: jumps and unconditional branches always resolve taken
    a_r5_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && br_kind != KIND_COND) |=> taken);
    // R7: index 31 suppresses the link write
    a_r7_no_link_r31: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && link_idx == ZERO_REG) |=> !link_we);
    // R1: aligned PC gives an aligned resolved address
    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && upd_pc[1:0] == 2'b00) |=> (res_next[1:0] == 2'b00));
    // R9: no mispredict means the guess matched
    a_r9_match: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mispredict) |-> (pred_next == res_next));
endmodule

// File: tb/branch_resolve_unit_bench.sv
module branch_resolve_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] upd_pc;
    logic [20:0] disp;
    logic [2:0]  cond_sel;
    logic        fp_test;
    logic [63:0] test_val;
    logic [1:0]  br_kind;
    logic [63:0] jump_base;
    logic [13:0] tgt_hint;
    logic [1:0]  flow_mark;
    logic [4:0]  link_idx;
    logic        out_valid, taken, mispredict, link_we;
    logic [63:0] pred_next, res_next, link_data;

    int errors = 0;
    int checks = 0;
    logic [63:0] mstk [4];
    int mcnt = 0;

    always #2.5 clk = ~clk;

    branch_resolve_unit u_branch_resolve_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .upd_pc(upd_pc),
        .disp(disp), .cond_sel(cond_sel), .fp_test(fp_test),
        .test_val(test_val), .br_kind(br_kind), .jump_base(jump_base),
        .tgt_hint(tgt_hint), .flow_mark(flow_mark), .link_idx(link_idx),
        .out_valid(out_valid), .pred_next(pred_next), .res_next(res_next),
        .taken(taken), .mispredict(mispredict), .link_we(link_we),
        .link_data(link_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic test_model(input logic [2:0] s, input logic fp, input logic [63:0] v);
        logic z, n;
        z = fp ? (v[62:0] == 63'd0) : (v == 64'd0);
        n = v[63] && !z;
        case (s)
            3'd0: return z;
            3'd1: return !z;
            3'd2: return n;
            3'd3: return n || z;
            3'd4: return !n && !z;
            3'd5: return !n;
            3'd6: return fp ? 1'b0 : !v[0];
            default: return fp ? 1'b0 : v[0];
        endcase
    endfunction

    function automatic logic [63:0] br_model(input logic [63:0] pc, input logic [20:0] d);
        return pc + {{41{d[20]}}, d, 2'b00};
    endfunction

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R10 idle valid", {63'd0, out_valid}, 64'd0);
        check("R10 idle flags", {61'd0, taken, mispredict, link_we}, 64'd0);
    endtask

    task automatic run_one(input logic [63:0] pc, input logic [20:0] d, input logic [2:0] s,
                           input logic fp, input logic [63:0] v, input logic [1:0] k,
                           input logic [63:0] jb, input logic [13:0] h, input logic [1:0] m,
                           input logic [4:0] li);
        logic [63:0] e_pred, e_res, e_link, bt;
        logic e_tk, e_ptk, e_mis, e_lwe, from_stack;
        string tk_tag, pred_tag;
        bt = br_model(pc, d);
        from_stack = 1'b0;
        if (k == 2'b00) begin
            e_tk   = test_model(s, fp, v);
            e_ptk  = d[20];
            e_pred = e_ptk ? bt : pc;
            e_res  = e_tk ? bt : pc;
            tk_tag = fp ? "R3 fp test" : "R2 int test";
            pred_tag = "R4 static guess";
        end else if (k == 2'b01) begin
            e_tk = 1'b1; e_ptk = 1'b1; e_pred = bt; e_res = bt;
            tk_tag = "R5 uncond taken";
            pred_tag = "R6 uncond guess";
        end else begin
            e_tk = 1'b1; e_ptk = 1'b1;
            e_res = {jb[63:2], 2'b00};
            if (m == 2'b10 && mcnt > 0) begin
                e_pred = mstk[0];
                from_stack = 1'b1;
            end else begin
                e_pred = {pc[63:16], h, 2'b00};
            end
            tk_tag = "R5 jump taken";
            pred_tag = from_stack ? "R8 stack guess" : "R6 hint guess";
        end
        e_mis  = (e_ptk != e_tk) || (e_pred != e_res);
        e_lwe  = (k != 2'b00) && (li != 5'd31);
        e_link = e_lwe ? pc : 64'd0;
        @(negedge clk);
        in_valid = 1'b1; upd_pc = pc; disp = d; cond_sel = s; fp_test = fp;
        test_val = v; br_kind = k; jump_base = jb; tgt_hint = h;
        flow_mark = m; link_idx = li;
        @(posedge clk);
        #1;
        if (m == 2'b01) begin
            for (int i = 3; i > 0; i--) mstk[i] = mstk[i-1];
            mstk[0] = pc;
            if (mcnt < 4) mcnt++;
        end else if (m == 2'b10 && mcnt > 0) begin
            for (int i = 0; i < 3; i++) mstk[i] = mstk[i+1];
            mstk[3] = 64'd0;
            mcnt--;
        end
        check("R10 valid", {63'd0, out_valid}, 64'd1);
        check(tk_tag, {63'd0, taken}, {63'd0, e_tk});
        check((k == 2'b10 || k == 2'b11) ? "R5 jump target" : "R1 resolved target", res_next, e_res);
        check(pred_tag, pred_next, e_pred);
        check("R9 mispredict", {63'd0, mispredict}, {63'd0, e_mis});
        check("R7 link we", {63'd0, link_we}, {63'd0, e_lwe});
        check("R7 link data", link_data, e_link);
        in_valid = 1'b0;
    endtask

    function automatic logic [63:0] pick_val();
        case ($urandom_range(0, 6))
            0: return 64'd0;
            1: return 64'd1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'd2;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [63:0] pcs [5];
        int unused_seed;
        unused_seed = $urandom(20240611);
        rst_n = 1'b0; in_valid = 1'b0; upd_pc = '0; disp = '0; cond_sel = '0;
        fp_test = 1'b0; test_val = '0; br_kind = '0; jump_base = '0;
        tgt_hint = '0; flow_mark = '0; link_idx = '0;
        for (int i = 0; i < 4; i++) mstk[i] = 64'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset valid", {63'd0, out_valid}, 64'd0);
        check("R10 reset outputs", pred_next | res_next | link_data, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 every integer selector against zero, one, minus one
        for (int s = 0; s < 8; s++) begin
            run_one(64'h1000, 21'h000010, 3'(s), 1'b0, 64'd0, 2'b00, '0, '0, 2'b00, 5'd1);
            run_one(64'h1000, 21'h1FFFF0, 3'(s), 1'b0, 64'd1, 2'b00, '0, '0, 2'b00, 5'd1);
            run_one(64'h1000, 21'h000010, 3'(s), 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, '0, '0, 2'b00, 5'd1);
        end
        // R3 negative zero and fp parity selectors
        for (int s = 0; s < 8; s++) begin
            run_one(64'h2000, 21'h000004, 3'(s), 1'b1, 64'h8000_0000_0000_0000, 2'b00, '0, '0, 2'b00, 5'd1);
            run_one(64'h2000, 21'h000004, 3'(s), 1'b1, 64'h8000_0000_0000_0003, 2'b00, '0, '0, 2'b00, 5'd1);
        end
        // R7 index 31 drops the link write
        run_one(64'h3000, 21'h000100, 3'd0, 1'b0, 64'd0, 2'b01, '0, '0, 2'b00, 5'd31);
        run_one(64'h3000, 21'h000100, 3'd0, 1'b0, 64'd0, 2'b10, 64'h7777, 14'h1DDD, 2'b00, 5'd31);
        idle_check();
        // R8 overflow: five calls, then five returns
        for (int i = 0; i < 5; i++) begin
            pcs[i] = 64'h4_0000 + 64'(i) * 64'h100;
            run_one(pcs[i], 21'h000040, 3'd0, 1'b0, 64'd0, 2'b01, '0, '0, 2'b01, 5'd26);
        end
        for (int i = 4; i >= 0; i--) begin
            run_one(64'h9_0000, 21'd0, 3'd0, 1'b0, 64'd0, 2'b10, pcs[i], 14'h0ABC, 2'b10, 5'd31);
        end
        idle_check();

        // random mix
        for (int n = 0; n < 3000; n++) begin
            run_one({$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_FFFC,
                    21'($urandom), 3'($urandom), 1'($urandom), pick_val(),
                    2'($urandom), {$urandom, $urandom}, 14'($urandom),
                    2'($urandom), 5'($urandom_range(28, 31)));
            if ($urandom_range(0, 15) == 0) idle_check();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule